// File: doc/BRIEF.md
# Configurable Multilevel Pipeline Register

This block keeps four byte-wide storage stages, grouped as an upper pair (first level `a_lvl1`, second level `a_lvl2`) and a lower pair (`b_lvl1`, `b_lvl2`). All four are loaded from a single byte input. A two-bit operation code, sampled on each rising clock edge, sets the transfer. The stages can act as one four-deep shift chain, or as two independent two-deep pipelines whose first levels are loaded separately.

A two-bit read select sends any one stage to the byte output. An active-low output enable gates that output. With the enable released, the data output is zero and a valid flag is low. The parameter `PUSH_DOWN` picks how a first-level load behaves. When it is 1, the old first-level value drops into the second level of the same pair. When it is 0, only the first level is replaced, and data reaches a second level only through the four-deep shift.

Top module: `mlpipe_reg`

## Requirements
- R1: A synchronous active-low reset (`rst_n` = 0 at a rising edge) clears all four stages to zero.
- R2: Operation code 3 is hold. No stage changes at that edge.
- R3: Operation code 0 shifts the full chain at one edge: input goes to a_lvl1, a_lvl1 to a_lvl2, a_lvl2 to b_lvl1, and b_lvl1 to b_lvl2.
- R4: Operation code 2 loads the input into a_lvl1. With PUSH_DOWN=1, the old a_lvl1 moves to a_lvl2 at the same edge. With PUSH_DOWN=0, a_lvl2 keeps its value. The b stages are unchanged in both cases.
- R5: Operation code 1 loads the input into b_lvl1. With PUSH_DOWN=1, the old b_lvl1 moves to b_lvl2 at the same edge. With PUSH_DOWN=0, b_lvl2 keeps its value. The a stages are unchanged in both cases.
- R6: The read select chooses the stage shown at the output: 0 gives b_lvl2, 1 gives b_lvl1, 2 gives a_lvl2 and 3 gives a_lvl1. The select path is combinational.
- R7: When `oe_n` is 0, `dout_vld` is 1 and `dout` shows the selected stage. When `oe_n` is 1, `dout_vld` is 0 and `dout` is zero. Neither state affects the stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low clear |
| din | input | W | Shared byte input |
| op | input | 2 | Operation code |
| rd_sel | input | 2 | Stage select for the output |
| oe_n | input | 1 | Active-low output enable |
| dout | output | W | Selected stage, or zero when disabled |
| dout_vld | output | 1 | High while the output is enabled |

## Verification
A transfer set up by `op` and `din` before a rising edge appears in the stages one edge later. The bench drives inputs on the falling edge and updates its model at the rising edge. It then reads every stage through `rd_sel` at points away from the rising edge. `rd_sel` and `oe_n` act combinationally. The output is therefore checked a short delay after those inputs change, with no clock edge between.

// File: rtl/mlpipe_reg.sv
module mlpipe_reg #(
  parameter int W = 8,
  parameter bit PUSH_DOWN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic [1:0]   op,
  input  logic [1:0]   rd_sel,
  input  logic         oe_n,
  output logic [W-1:0] dout,
  output logic         dout_vld
);
  localparam logic [1:0] OP_SHIFT = 2'd0, OP_LDB = 2'd1, OP_LDA = 2'd2;

  logic [W-1:0] a1, a2, b1, b2, sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a1 <= '0; a2 <= '0; b1 <= '0; b2 <= '0;
    end else begin
      case (op)
        OP_SHIFT: begin
          a1 <= din; a2 <= a1; b1 <= a2; b2 <= b1;
        end
        OP_LDA: begin
          a1 <= din;
          if (PUSH_DOWN) a2 <= a1;
        end
        OP_LDB: begin
          b1 <= din;
          if (PUSH_DOWN) b2 <= b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_sel)
      2'd0: sel_q = b2;
      2'd1: sel_q = b1;
      2'd2: sel_q = a2;
      default: sel_q = a1;
    endcase
  end

  assign dout_vld = ~oe_n;
  assign dout     = oe_n ? '0 : sel_q;
endmodule

module mlpipe_reg_chk #(
  parameter int W = 8,
  parameter bit PUSH_DOWN = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] din,
  input logic [1:0]   op,
  input logic         oe_n,
  input logic [W-1:0] dout,
  input logic         dout_vld,
  input logic [W-1:0] a1,
  input logic [W-1:0] a2,
  input logic [W-1:0] b1,
  input logic [W-1:0] b2
);
  a_r1_clear: assert property (@(posedge clk) !rst_n |=> (a1 == '0 && a2 == '0 && b1 == '0 && b2 == '0));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    op == 2'd3 |=> ($stable(a1) && $stable(a2) && $stable(b1) && $stable(b2)));
  a_r3_shift: assert property (@(posedge clk) disable iff (!rst_n)
    op == 2'd0 |=> (a1 == $past(din) && a2 == $past(a1) && b1 == $past(a2) && b2 == $past(b1)));
  a_r4_load_a: assert property (@(posedge clk) disable iff (!rst_n)
    op == 2'd2 |=> (a1 == $past(din) && $stable(b1) && $stable(b2) &&
                    (PUSH_DOWN ? a2 == $past(a1) : $stable(a2))));
  a_r5_load_b: assert property (@(posedge clk) disable iff (!rst_n)
    op == 2'd1 |=> (b1 == $past(din) && $stable(a1) && $stable(a2) &&
                    (PUSH_DOWN ? b2 == $past(b1) : $stable(b2))));
  a_r7_disabled: assert property (@(posedge clk) oe_n |-> (!dout_vld && dout == '0));
endmodule

bind mlpipe_reg mlpipe_reg_chk #(.W(W), .PUSH_DOWN(PUSH_DOWN)) chk_i (
  .clk(clk), .rst_n(rst_n), .din(din), .op(op), .oe_n(oe_n),
  .dout(dout), .dout_vld(dout_vld), .a1(a1), .a2(a2), .b1(b1), .b2(b2));

// File: tb/mlpipe_reg_tb.sv
module mlpipe_reg_tb_top;
  localparam int W = 8;
  localparam bit PD = 1'b1;
  logic clk = 0, rst_n = 0, oe_n = 0;
  logic [W-1:0] din = '0;
  logic [1:0] op = 2'd3, rd_sel = '0;
  logic [W-1:0] dout;
  logic dout_vld;
  int n_cmp = 0, n_bad = 0;
  logic [W-1:0] m[4];
  bit done = 0;

  always #5 clk = ~clk;

  mlpipe_reg #(.W(W), .PUSH_DOWN(PD)) dut_i (.*);

  function automatic logic [W-1:0] pick(input logic [1:0] s);
    return s == 0 ? m[3] : s == 1 ? m[2] : s == 2 ? m[1] : m[0];
  endfunction

  task automatic model_step(input logic [1:0] o, input logic [W-1:0] d);
    logic [W-1:0] a1, a2, b1, b2;
    a1 = m[0]; a2 = m[1]; b1 = m[2]; b2 = m[3];
    case (o)
      2'd0: begin m[0] = d; m[1] = a1; m[2] = a2; m[3] = b1; end
      2'd2: begin m[0] = d; if (PD) m[1] = a1; end
      2'd1: begin m[2] = d; if (PD) m[3] = b1; end
      default: ;
    endcase
  endtask

  task automatic cmp(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int s = 0; s < 4; s++) begin
      rd_sel = s[1:0]; #1;
      cmp(req, dout, pick(s[1:0]));
    end
  endtask

  task automatic step(input logic [1:0] o, input logic [W-1:0] d, input string req);
    @(negedge clk); op = o; din = d;
    @(posedge clk); model_step(o, d);
    @(negedge clk); op = 2'd3;
    check_all(req);
  endtask

  initial begin
    void'($urandom(1234));
    for (int i = 0; i < 4; i++) m[i] = '0;
    din = 8'hFF; op = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; op = 2'd3;
    check_all("R1");
    step(2'd0, 8'h11, "R3"); step(2'd0, 8'h22, "R3");
    step(2'd0, 8'h33, "R3"); step(2'd0, 8'h44, "R3");
    step(2'd3, 8'hEE, "R2");
    step(2'd2, 8'h55, "R4"); step(2'd2, 8'h66, "R4");
    step(2'd1, 8'h77, "R5"); step(2'd1, 8'h88, "R5");
    @(negedge clk); oe_n = 1;
    for (int s = 0; s < 4; s++) begin
      rd_sel = s[1:0]; #1;
      cmp("R7", dout, '0); cmp("R7", {7'd0, dout_vld}, 8'd0);
    end
    oe_n = 0; #1;
    cmp("R7", {7'd0, dout_vld}, 8'd1);
    check_all("R6");
    for (int k = 0; k < 300; k++) step(2'($urandom_range(0, 3)), 8'($urandom), "R6");
    @(negedge clk); op = 2'd0; din = 8'hAB; rst_n = 0;
    @(posedge clk); for (int i = 0; i < 4; i++) m[i] = '0;
    @(negedge clk); rst_n = 1; op = 2'd3;
    check_all("R1");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (50000) @(posedge clk); n_cmp++; n_bad++; $display("FAIL watchdog act=0 exp=1"); end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule